// File: doc/BRIEF.md
# Partition-Halving March Test Engine

This block is a built-in self-test sequencer for a single-port synchronous memory of up to 2^ADDR_W words of DATA_W bits. After a start pulse it clears the tested range to zero. It then runs a series of passes. Each pass fixes a partition size P, starting at half the address space and halving down to MIN_PART. Within a pass, an eight-step table decides which half of every 2P-word block is written, with which value, and what the opposite half must read back. The result is a sequence that brings out address-decoder faults and coupling between distant bit groups.

The engine issues one memory access per cycle on registered outputs. It compares every read against the expected all-zeros or all-ones word and reports each mismatch with its logical address and the failing bits. An optional fixed logical-to-physical address mapping can be switched in at start. A stop request ends the run cleanly at the next step boundary. Completion is signalled by a done flag, next to a sticky fail flag.

Top module: `halfmarch_bist`

## Requirements
- R1: After start, the engine first writes zero to every logical address from 0 up to word_count-1, in ascending order, one write per cycle.
- R2: Passes then run with P = 2^(ADDR_W-1), 2^(ADDR_W-2), ... down to MIN_PART (1024 down to 8 by default). Each pass has exactly 8 steps, and no other accesses occur.
- R3: Step s (0..7) first writes the half given by the upper-select list (1,1,0,1,0,0,1,0), using all-ones where the write list (1,0,1,1,0,1,0,0) has 1 and zeros otherwise. It then reads the opposite half, expecting all-ones where the read list (0,0,0,1,1,1,1,0) has 1 and zeros otherwise.
- R4: A half walk starts at P (upper) or 0 (lower) and steps by one. On an upper walk, an address whose value mod 2P is 0 is advanced by P. On a lower walk, an address whose value mod 2P equals P is advanced by P. The walk issues no access at or beyond word_count, so a walk starting there is empty.
- R5: Every write carries a word of all zeros or all ones.
- R6: Each read whose returned word differs from the expected one raises err_valid for one cycle, in the cycle after the read data. err_addr holds the logical address and err_bits the XOR of returned and expected words. fail is set by any mismatch and stays set until the next start.
- R7: With map_en high at start, the issued address is the logical address plus 192 (mod 2048), with bits rearranged so that physical bits [10:3] take logical bits 3,10,5,4,7,6,9,8 (from bit 10 down), bits [2:0] kept, and the result XORed with 0x7F0. With map_en low, the logical address is issued unchanged.
- R8: A stop pulse during a run lets the current step finish, or the clear phase if it is running, and then issues no further accesses before done.
- R9: busy is high from the cycle after start until the run ends. done then rises, stays high with busy low until the next start, and the run never raises both.
- R10: After reset, mem_en, busy, done, fail and err_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| stop | input | 1 | Request early end at next step boundary |
| map_en | input | 1 | Use the physical address mapping for this run |
| word_count | input | ADDR_W+1 | Number of words tested, at most 2^ADDR_W |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read access |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky: a mismatch was seen in this run |
| err_valid | output | 1 | Mismatch report this cycle |
| err_addr | output | ADDR_W | Logical address of the mismatching read |
| err_bits | output | DATA_W | Failing bits (XOR of read and expected) |

## Verification
The bound checker watches, on every cycle, that written words are uniform, that accesses occur only while busy, and that busy and done exclude each other. It also checks that done and fail hold until a new start, and that a mismatch report always carries nonzero failing bits and sets fail. The order and addresses of the walks, the table-driven data, the address mapping, the stop boundary and the exact error reports can only be shown by the bench scenarios. There, a reference walk with a shadow memory and an injected stuck-bit fault predicts every access and every error.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

  // Per-step table bits, bit index = step number.
  localparam logic [7:0] STEP_UPPER   = 8'h4B;  // write half is the upper half
  localparam logic [7:0] STEP_WR_ONES = 8'h2D;  // write data is all ones
  localparam logic [7:0] STEP_RD_ONES = 8'h78;  // read expects all ones

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLEAR, ST_WRITE, ST_READ, ST_BOUND, ST_DRAIN, ST_DONE
  } state_t;

  // Fixed logical-to-physical mapping for an 11-bit address space.
  function automatic logic [10:0] phys_map(input logic [10:0] la);
    logic [10:0] b;
    logic [10:0] p;
    b = la + 11'd192;
    p = {b[3], b[10], b[5], b[4], b[7], b[6], b[9], b[8], b[2:0]};
    return p ^ 11'h7F0;
  endfunction

endpackage

// File: rtl/hmb_walker.sv
module hmb_walker #(
  parameter int ADDR_W = 11,
  parameter int PL_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic              linear,
  input  logic              upper,
  input  logic [PL_W-1:0]   part_log,
  input  logic [ADDR_W:0]   count,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam int AW = ADDR_W + 2;

  logic [AW-1:0]   a_q, a_next, inc, start_a, p_val, span_mask, ofs;
  logic            lin_q, up_q, jump;
  logic [PL_W-1:0] pl_q;

  always_comb begin
    start_a   = (!linear && upper) ? (AW'(1) << part_log) : '0;
    p_val     = AW'(1) << pl_q;
    span_mask = (p_val << 1) - AW'(1);
    inc       = a_q + AW'(1);
    ofs       = inc & span_mask;
    jump      = !lin_q && ((up_q && ofs == '0) || (!up_q && ofs == p_val));
    a_next    = jump ? (inc + p_val) : inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      lin_q <= 1'b1;
      up_q  <= 1'b0;
      pl_q  <= '0;
    end else if (load) begin
      a_q   <= start_a;
      lin_q <= linear;
      up_q  <= upper;
      pl_q  <= part_log;
    end else if (adv) begin
      a_q   <= a_next;
    end
  end

  assign at_end = a_q >= AW'(count);
  assign addr   = a_q[ADDR_W-1:0];

endmodule

// File: rtl/hmb_compare.sv
module hmb_compare #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_rd,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              issue_ones,
  input  logic [DATA_W-1:0] rdata,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_bits
);
  logic              s1_v, s2_v, s1_o, s2_o;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [DATA_W-1:0] diff;

  assign diff = rdata ^ {DATA_W{s2_o}};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      s1_o      <= 1'b0;
      s2_o      <= 1'b0;
      s1_a      <= '0;
      s2_a      <= '0;
      err_valid <= 1'b0;
      err_addr  <= '0;
      err_bits  <= '0;
    end else begin
      // stage 1: access on the memory port, stage 2: read data returned
      s1_v      <= issue_rd;
      s1_a      <= issue_addr;
      s1_o      <= issue_ones;
      s2_v      <= s1_v;
      s2_a      <= s1_a;
      s2_o      <= s1_o;
      err_valid <= s2_v && (diff != '0);
      if (s2_v) begin
        err_addr <= s2_a;
        err_bits <= diff;
      end
    end
  end

endmodule

// File: rtl/halfmarch_bist.sv
module halfmarch_bist #(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 32,
  parameter int MIN_PART = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              map_en,
  input  logic [ADDR_W:0]   word_count,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              err_valid,
  output logic [ADDR_W-1:0] err_addr,
  output logic [DATA_W-1:0] err_bits
);
  import hmb_pkg::*;

  localparam int PL_W   = $clog2(ADDR_W);
  localparam int TOP_PL = ADDR_W - 1;
  localparam int MIN_PL = $clog2(MIN_PART);

  state_t            state_q, state_n;
  logic [2:0]        step_q, step_n;
  logic [PL_W-1:0]   part_q, w_part;
  logic [ADDR_W:0]   count_q;
  logic              map_q, stop_req;
  logic [1:0]        drain_q;
  logic              w_load, w_adv, w_linear, w_upper, w_end;
  logic [ADDR_W-1:0] w_addr, phys_a;
  logic              iss, iss_we, iss_ones;
  logic              last_step, last_pass;

  hmb_walker #(.ADDR_W(ADDR_W), .PL_W(PL_W)) u_walk (
    .clk(clk), .rst(rst), .load(w_load), .adv(w_adv), .linear(w_linear),
    .upper(w_upper), .part_log(w_part), .count(count_q),
    .addr(w_addr), .at_end(w_end)
  );

  logic              cmp_err;
  hmb_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .issue_rd(iss && !iss_we), .issue_addr(w_addr),
    .issue_ones(iss_ones), .rdata(mem_rdata),
    .err_valid(cmp_err), .err_addr(err_addr), .err_bits(err_bits)
  );
  assign err_valid = cmp_err;

  generate
    if (ADDR_W == 11) begin : g_map
      assign phys_a = map_q ? phys_map(w_addr) : w_addr;
    end else begin : g_nomap
      assign phys_a = w_addr;
    end
  endgenerate

  assign last_step = (step_q == 3'd7);
  assign last_pass = (part_q == PL_W'(MIN_PL));

  always_comb begin
    state_n  = state_q;
    step_n   = step_q + 3'd1;
    w_load   = 1'b0;
    w_adv    = 1'b0;
    w_linear = 1'b0;
    w_upper  = 1'b0;
    w_part   = part_q;
    iss      = 1'b0;
    iss_we   = 1'b0;
    iss_ones = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          w_load   = 1'b1;
          w_linear = 1'b1;
          state_n  = ST_CLEAR;
        end
      end
      ST_CLEAR: begin
        if (w_end) begin
          if (stop_req) state_n = ST_DRAIN;
          else begin
            w_load  = 1'b1;
            w_upper = STEP_UPPER[step_q];
            state_n = ST_WRITE;
          end
        end else begin
          iss    = 1'b1;
          iss_we = 1'b1;
          w_adv  = 1'b1;
        end
      end
      ST_WRITE: begin
        if (w_end) begin
          w_load  = 1'b1;
          w_upper = !STEP_UPPER[step_q];
          state_n = ST_READ;
        end else begin
          iss      = 1'b1;
          iss_we   = 1'b1;
          iss_ones = STEP_WR_ONES[step_q];
          w_adv    = 1'b1;
        end
      end
      ST_READ: begin
        if (w_end) state_n = ST_BOUND;
        else begin
          iss      = 1'b1;
          iss_ones = STEP_RD_ONES[step_q];
          w_adv    = 1'b1;
        end
      end
      ST_BOUND: begin
        if ((last_step && last_pass) || stop_req) state_n = ST_DRAIN;
        else begin
          w_load  = 1'b1;
          w_part  = last_step ? (part_q - PL_W'(1)) : part_q;
          w_upper = STEP_UPPER[step_n];
          state_n = ST_WRITE;
        end
      end
      ST_DRAIN: begin
        if (drain_q == 2'd3) state_n = ST_DONE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      part_q    <= PL_W'(TOP_PL);
      count_q   <= '0;
      map_q     <= 1'b0;
      stop_req  <= 1'b0;
      drain_q   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q <= state_n;
      busy    <= (state_n != ST_IDLE) && (state_n != ST_DONE);
      done    <= (state_n == ST_DONE);
      if ((state_q == ST_IDLE || state_q == ST_DONE) && start) begin
        step_q   <= '0;
        part_q   <= PL_W'(TOP_PL);
        count_q  <= word_count;
        map_q    <= map_en;
        stop_req <= 1'b0;
        fail     <= 1'b0;
      end else begin
        if (busy && stop) stop_req <= 1'b1;
        if (cmp_err) fail <= 1'b1;
      end
      if (state_q == ST_BOUND && state_n == ST_WRITE) begin
        step_q <= step_n;
        part_q <= w_part;
      end
      drain_q   <= (state_q == ST_DRAIN) ? drain_q + 2'd1 : 2'd0;
      mem_en    <= iss;
      mem_we    <= iss && iss_we;
      mem_addr  <= phys_a;
      mem_wdata <= {DATA_W{iss_ones}};
    end
  end

endmodule

// File: rtl/hmb_checker.sv
module hmb_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              err_valid,
  input logic [DATA_W-1:0] err_bits
);
  // R5
  uniform_wdata_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> (mem_wdata == '0 || mem_wdata == '1));
  // R9
  access_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy);
  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);
  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !start) |=> fail);
  // R6
  err_sets_fail_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |=> fail);
  // R6
  err_bits_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_bits != '0));
endmodule

bind halfmarch_bist hmb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_en(mem_en), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .busy(busy), .done(done), .fail(fail),
  .err_valid(err_valid), .err_bits(err_bits)
);

// File: tb/tb_halfmarch_bist.sv
`timescale 1ns/1ps
module tb_halfmarch_bist;
  localparam int AW = 11;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0, stop = 1'b0, map_en = 1'b0;
  logic [AW:0]   word_count = '0;
  logic          mem_en, mem_we, busy, done, fail, err_valid;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_bits;

  always #2.5 clk = ~clk;

  halfmarch_bist #(.ADDR_W(AW), .DATA_W(DW), .MIN_PART(8)) dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .map_en(map_en),
    .word_count(word_count), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .err_valid(err_valid),
    .err_addr(err_addr), .err_bits(err_bits)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with one stuck-bit fault on reads
  logic [DW-1:0] mem [2048];
  bit            f_on = 0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_mask = '0, f_val = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else if (f_on && mem_addr == f_addr)
        mem_rdata <= (mem[mem_addr] & ~f_mask) | (f_val & f_mask);
      else mem_rdata <= mem[mem_addr];
    end
  end

  // reference tables from the requirement lists, index = step
  bit tb_up [8] = '{1,1,0,1,0,0,1,0};
  bit tb_wr [8] = '{1,0,1,1,0,1,0,0};
  bit tb_rd [8] = '{0,0,0,1,1,1,1,0};

  logic [DW-1:0] shadow [2048];
  bit            q_we [$];
  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_wd [$];
  int            q_tag [$];
  logic [AW-1:0] e_addr [$];
  logic [DW-1:0] e_bits [$];
  int unsigned   qi = 0, ei = 0, limit = 0;
  bit            cur_map = 0;

  function automatic logic [AW-1:0] ref_map(input logic [AW-1:0] la, input bit en);
    logic [AW-1:0] b, p;
    if (!en) return la;
    b = la + 11'd192;
    p[2:0] = b[2:0];
    p[3] = b[8];  p[4] = b[9];  p[5] = b[6];  p[6] = b[7];
    p[7] = b[4];  p[8] = b[5];  p[9] = b[10]; p[10] = b[3];
    return p ^ 11'h7F0;
  endfunction

  task automatic push_acc(input int la, input bit we, input bit ones, input int tag);
    logic [DW-1:0] v, ex;
    logic [AW-1:0] pa;
    pa = ref_map(AW'(la), cur_map);
    ex = ones ? '1 : '0;
    q_we.push_back(we); q_addr.push_back(pa); q_wd.push_back(ex); q_tag.push_back(tag);
    if (we) shadow[la] = ex;
    else begin
      v = shadow[la];
      if (f_on && pa == f_addr) v = (v & ~f_mask) | (f_val & f_mask);
      if (v != ex) begin e_addr.push_back(AW'(la)); e_bits.push_back(v ^ ex); end
    end
  endtask

  task automatic half_walk(input int p, input bit up, input bit we, input bit ones, input int cnt, input int tag);
    int a = up ? p : 0;
    while (a < cnt) begin
      push_acc(a, we, ones, tag);
      a = a + 1;
      if (up && (a % (2*p)) == 0) a = a + p;
      else if (!up && (a % (2*p)) == p) a = a + p;
    end
  endtask

  task automatic build_ref(input int cnt);
    int tag = 0;
    q_we.delete(); q_addr.delete(); q_wd.delete(); q_tag.delete();
    e_addr.delete(); e_bits.delete(); qi = 0; ei = 0;
    for (int a = 0; a < cnt; a++) push_acc(a, 1, 0, 0);
    for (int pl = 10; pl >= 3; pl--)
      for (int s = 0; s < 8; s++) begin
        tag++;
        half_walk(1 << pl, tb_up[s], 1, tb_wr[s], cnt, tag);
        half_walk(1 << pl, !tb_up[s], 0, tb_rd[s], cnt, tag);
      end
  endtask

  // access and error monitors
  always @(negedge clk) begin
    if (!rst && mem_en) begin
      if (qi >= limit) chk(0, "R2 R8 extra access", {32'd0, 20'd0, mem_addr}, 64'd0);
      else begin
        chk(mem_we == q_we[qi] && mem_addr == q_addr[qi] && (!mem_we || mem_wdata == q_wd[qi]),
            q_tag[qi] == 0 ? "R1 R7 clear access" : "R2 R3 R4 R5 R7 walk access",
            {12'd0, mem_we, mem_addr, mem_wdata}, {12'd0, q_we[qi], q_addr[qi], q_wd[qi]});
        qi++;
      end
    end
    if (!rst && err_valid) begin
      if (ei >= e_addr.size()) chk(0, "R6 unexpected error", {21'd0, err_addr, err_bits}, 64'd0);
      else chk(err_addr == e_addr[ei] && err_bits == e_bits[ei], "R6 error report",
               {21'd0, err_addr, err_bits}, {21'd0, e_addr[ei], e_bits[ei]});
      ei++;
    end
  end

  task automatic run(input int cnt, input bit men, input bit fault, input int stop_at);
    int la;
    word_count = (AW+1)'(cnt); map_en = men; cur_map = men; f_on = fault;
    if (fault) begin
      la = $urandom % cnt;
      f_addr = ref_map(AW'(la), men);
      f_mask = $urandom | 32'h1;
      f_val = $urandom;
    end
    build_ref(cnt);
    limit = q_we.size();
    if (stop_at > 0) begin
      limit = 0;
      foreach (q_tag[i]) if (q_tag[i] <= q_tag[stop_at-1]) limit = i + 1;
    end
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy && !done, "R9 busy after start", {62'd0, busy, done}, 64'd2);
    if (stop_at > 0) begin
      wait (qi == stop_at);
      stop = 1;
      @(negedge clk) stop = 0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(qi == limit, stop_at > 0 ? "R8 stop at step boundary" : "R2 access count", 64'(qi), 64'(limit));
    chk(ei == e_addr.size(), "R6 error count", 64'(ei), 64'(e_addr.size()));
    chk(fail == (e_addr.size() != 0), "R6 sticky fail", 64'(fail), 64'(e_addr.size() != 0));
    chk(done && !busy && !mem_en, "R9 done holds idle", {61'd0, done, busy, mem_en}, 64'd4);
  endtask

  initial begin
    process_seed: begin int unsigned s; s = $urandom(32'd1234); end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!mem_en && !busy && !done && !fail && !err_valid, "R10 reset state",
        {59'd0, mem_en, busy, done, fail, err_valid}, 64'd0);
    run(768, 0, 0, 0);          // fault-free, upper halves empty at largest P
    run(600, 1, 1, 0);          // mapped addresses, stuck bits
    run(300 + ($urandom % 40), 0, 1, 0);
    run(512, 1, 0, 4 * 512 + 2 * 512 + 17); // stop mid-step, clears fail
    run(512, 0, 0, 100);        // stop during clear phase
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule